// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the target side of a serial flash memory interface. A host drives chip-select, a serial clock and four data lines. The block decodes an 8-bit opcode. On a read command it streams bytes out of a small internal array from a 24-bit start address and keeps streaming for as long as chip-select stays low. A second opcode moves the bus from single-bit transfers to 4-bit transfers. That bus mode is kept across commands until a dedicated return opcode or a reset clears it.

The serial inputs are brought into the system clock domain through synchronisers. Edges of the serial clock are then detected there, so all decoding and output logic runs on one fast clock. Because of this, every serial clock phase must last several system clock periods. A write port lets a testbench or loader fill the storage array before use.

Top module: `sqflash_front`

## Requirements
- R1: In single-bit mode, opcode 03h on `sio_in[0]` (MSB first), followed by 24 address bits sent MSB first, starts a read. The bytes come out MSB first on `sio_out[1]`, beginning at the address formed by the low log2(DEPTH) address bits. DEPTH is a power of two, and the upper address bits are ignored.
- R2: While `cs_n` stays low, bytes stream without a break, and the array pointer advances by one for each byte.
- R3: After the byte at address DEPTH-1, the stream continues from address 0.
- R4: Within 4 `clk` cycles of `cs_n` going high, `sio_oe` is all zero and the command in progress is abandoned. The next command is decoded from a fresh opcode.
- R5: `sio_oe` is zero while the opcode and address are shifted in. During the data phase it equals 4'b0010, so only lane 1 drives.
- R6: In quad mode, opcode 03h is ignored, and `sio_oe` stays zero until `cs_n` rises.
- R7: Opcode 38h received in single-bit mode enters quad mode. Later opcodes then take one nibble per rising `sck` edge on `sio_in[3:0]`, high nibble first, two edges per opcode.
- R8: Quad mode survives any number of `cs_n` high periods. Only opcode FFh received in quad mode, or `rst`, returns the block to single-bit mode.
- R9: Decoding is the same whether `sck` idles low (mode 0) or high (mode 3) when `cs_n` falls.
- R10: Inputs are sampled on rising `sck` edges, and outputs change after falling `sck` edges. The first data bit is valid before the rising edge that follows the last address bit. This requires each `sck` phase to last at least SYNC_STAGES+3 `clk` periods.
- R11: Any other opcode leaves `sio_oe` at zero until `cs_n` next rises.
- R12: A `pl_we` pulse writes `pl_data` to array location `pl_addr` on the rising `clk` edge. Later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than `sck` |
| rst | input | 1 | Synchronous active-high reset, clears quad mode |
| cs_n | input | 1 | Chip select from the host, active low |
| sck | input | 1 | Serial clock from the host |
| sio_in | input | 4 | Input values of the four data lines |
| sio_out | output | 4 | Output values of the four data lines |
| sio_oe | output | 4 | Per-lane output enable, 1 = drive |
| pl_we | input | 1 | Array write strobe |
| pl_addr | input | log2(DEPTH) | Array write address |
| pl_data | input | 8 | Array write data |

## Verification
The bench goes after the address wrap by starting reads just below the top of the array and by giving start addresses with high bits set. A pointer that overruns, or that keeps high address bits, returns the wrong bytes after location DEPTH-1. Bus-mode persistence is probed by sending read commands in quad mode across several chip-select cycles and before and after the FFh return. A design that clears the mode on deselect, or that honours the read in quad mode, would drive lane 1. Mode 3 starts, aborts in the middle of a byte and unknown opcodes check that a stale bit counter or stale phase does not shift the next command's data or leave a lane driven.

// File: rtl/sqf_pkg.sv
package sqf_pkg;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_ADDR   = 2'd1,
    PH_DATA   = 2'd2,
    PH_IGNORE = 2'd3
  } phase_t;

  localparam logic [7:0] OPC_READ     = 8'h03;
  localparam logic [7:0] OPC_QUAD_ON  = 8'h38;
  localparam logic [7:0] OPC_QUAD_OFF = 8'hFF;

  localparam int ADDR_BITS = 24;
  localparam int BYTE_W    = 8;
  localparam int LANES     = 4;

endpackage

// File: rtl/sqf_sync_edge.sv
module sqf_sync_edge #(
  parameter int STAGES = 2,
  parameter int LANES  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic [LANES-1:0] sio_in,
  output logic             cs_idle,
  output logic             sck_rise,
  output logic             sck_fall,
  output logic [LANES-1:0] sio_s
);

  localparam int W = LANES + 2;
  localparam logic [W-1:0] RST_V = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] stage [STAGES];
  logic         sck_last;
  logic         sck_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_V;
    end else begin
      stage[0] <= {cs_n, sck, sio_in};
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign sck_now = stage[STAGES-1][LANES];

  always_ff @(posedge clk) begin
    if (rst) sck_last <= 1'b0;
    else     sck_last <= sck_now;
  end

  assign cs_idle  = stage[STAGES-1][W-1];
  assign sio_s    = stage[STAGES-1][LANES-1:0];
  assign sck_rise = sck_now & ~sck_last;
  assign sck_fall = ~sck_now & sck_last;

endmodule

// File: rtl/sqf_cmd_decode.sv
module sqf_cmd_decode
  import sqf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_idle,
  input  logic             sck_rise,
  input  logic [LANES-1:0] sio_s,
  output logic             quad_mode,
  output logic             rd_start,
  output logic [AW-1:0]    rd_addr
);

  localparam int CNT_W = $clog2(ADDR_BITS);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] op_sr;
  logic [BYTE_W-1:0] op_next;
  logic [AW-1:0]     addr_sr;
  logic [AW-1:0]     addr_next;
  logic              op_done;

  // high nibble arrives first in quad mode
  assign op_next   = quad_mode ? {op_sr[3:0], sio_s} : {op_sr[BYTE_W-2:0], sio_s[0]};
  assign op_done   = quad_mode ? (cnt == CNT_W'(1)) : (cnt == CNT_W'(BYTE_W - 1));
  assign addr_next = {addr_sr[AW-2:0], sio_s[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_OPCODE;
      cnt       <= '0;
      op_sr     <= '0;
      addr_sr   <= '0;
      quad_mode <= 1'b0;
      rd_start  <= 1'b0;
      rd_addr   <= '0;
    end else begin
      rd_start <= 1'b0;
      if (cs_idle) begin
        phase <= PH_OPCODE;
        cnt   <= '0;
      end else if (sck_rise) begin
        unique case (phase)
          PH_OPCODE: begin
            op_sr <= op_next;
            cnt   <= cnt + CNT_W'(1);
            if (op_done) begin
              cnt <= '0;
              if (!quad_mode && op_next == OPC_READ) begin
                phase <= PH_ADDR;
              end else if (!quad_mode && op_next == OPC_QUAD_ON) begin
                quad_mode <= 1'b1;
                phase     <= PH_IGNORE;
              end else if (quad_mode && op_next == OPC_QUAD_OFF) begin
                quad_mode <= 1'b0;
                phase     <= PH_IGNORE;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          PH_ADDR: begin
            addr_sr <= addr_next;
            cnt     <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(ADDR_BITS - 1)) begin
              phase    <= PH_DATA;
              rd_start <= 1'b1;
              rd_addr  <= addr_next;
            end
          end
          default: phase <= phase;
        endcase
      end
    end
  end

endmodule

// File: rtl/sqf_mem.sv
module sqf_mem #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/sqf_serializer.sv
module sqf_serializer #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_idle,
  input  logic          sck_fall,
  input  logic          rd_start,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] rd_ptr,
  output logic          so_bit,
  output logic          so_en
);

  logic          active;
  logic [BW-1:0] bitpos;
  logic [DW-1:0] shreg;
  logic [AW-1:0] ptr_next;

  assign ptr_next = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      bitpos <= '0;
      shreg  <= '0;
      so_bit <= 1'b0;
      so_en  <= 1'b0;
      rd_ptr <= '0;
    end else if (cs_idle) begin
      active <= 1'b0;
      so_en  <= 1'b0;
      bitpos <= '0;
    end else if (rd_start) begin
      rd_ptr <= rd_addr;
      active <= 1'b1;
      bitpos <= '0;
    end else if (sck_fall && active) begin
      so_en  <= 1'b1;
      bitpos <= bitpos + BW'(1);
      if (bitpos == '0) begin
        so_bit <= mem_q[DW-1];
        shreg  <= {mem_q[DW-2:0], 1'b0};
        rd_ptr <= ptr_next;
      end else begin
        so_bit <= shreg[DW-1];
        shreg  <= {shreg[DW-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/sqflash_front.sv
module sqflash_front
  import sqf_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic [3:0]    sio_in,
  output logic [3:0]    sio_out,
  output logic [3:0]    sio_oe,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data
);

  logic             cs_idle;
  logic             sck_rise;
  logic             sck_fall;
  logic [LANES-1:0] sio_s;
  logic             quad_mode;
  logic             rd_start;
  logic [AW-1:0]    rd_addr;
  logic [AW-1:0]    rd_ptr;
  logic [BYTE_W-1:0] mem_q;
  logic             so_bit;
  logic             so_en;

  sqf_sync_edge #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sck     (sck),
    .sio_in  (sio_in),
    .cs_idle (cs_idle),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .sio_s   (sio_s)
  );

  sqf_cmd_decode #(.AW(AW)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .cs_idle  (cs_idle),
    .sck_rise (sck_rise),
    .sio_s    (sio_s),
    .quad_mode(quad_mode),
    .rd_start (rd_start),
    .rd_addr  (rd_addr)
  );

  sqf_mem #(.DEPTH(DEPTH), .DW(BYTE_W)) u_mem (
    .clk  (clk),
    .we   (pl_we),
    .waddr(pl_addr),
    .wdata(pl_data),
    .raddr(rd_ptr),
    .rdata(mem_q)
  );

  sqf_serializer #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .cs_idle (cs_idle),
    .sck_fall(sck_fall),
    .rd_start(rd_start),
    .rd_addr (rd_addr),
    .mem_q   (mem_q),
    .rd_ptr  (rd_ptr),
    .so_bit  (so_bit),
    .so_en   (so_en)
  );

  // single-bit data leaves on lane 1; both are registers in the serializer
  assign sio_out = {2'b00, so_bit, 1'b0};
  assign sio_oe  = {2'b00, so_en, 1'b0};

endmodule

// File: rtl/sqf_checker.sv
module sqf_checker #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_idle,
  input logic          quad_mode,
  input logic          rd_start,
  input logic [AW-1:0] rd_ptr,
  input logic [3:0]    sio_oe
);

  AST_RELEASE_HIZ: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (sio_oe == 4'b0000)); // R4

  AST_QUAD_SILENT: assert property (@(posedge clk) disable iff (rst)
    quad_mode |-> (sio_oe == 4'b0000)); // R6

  AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((rd_ptr != $past(rd_ptr)) && !$past(rd_start)) |->
      (rd_ptr == (($past(rd_ptr) == AW'(DEPTH - 1)) ? AW'(0) : $past(rd_ptr) + AW'(1)))); // R3

  AST_MODE_KEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> $stable(quad_mode)); // R8

endmodule

bind sqflash_front sqf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_idle  (cs_idle),
  .quad_mode(quad_mode),
  .rd_start (rd_start),
  .rd_ptr   (rd_ptr),
  .sio_oe   (sio_oe)
);

// File: tb/sqflash_front_tb.sv
module sqflash_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DEPTH      = 256;
  localparam int AW         = 8;
  localparam int NVEC       = 6;

  // {mode3, start address, byte count}
  localparam logic [28:0] VECS [NVEC] = '{
    {1'b0, 24'h000000, 4'd4},
    {1'b1, 24'h000031, 4'd3},
    {1'b0, 24'h0000FD, 4'd5},
    {1'b1, 24'h5A00FF, 4'd2},
    {1'b0, 24'h000080, 4'd6},
    {1'b1, 24'hFFFFFE, 4'd3}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          sck = 1'b0;
  logic [3:0]    sio_in = 4'hF;
  logic [3:0]    sio_out;
  logic [3:0]    sio_oe;
  logic          pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0]    pl_data = '0;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  sqflash_front #(.DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .sck    (sck),
    .sio_in (sio_in),
    .sio_out(sio_out),
    .sio_oe (sio_oe),
    .pl_we  (pl_we),
    .pl_addr(pl_addr),
    .pl_data(pl_data)
  );

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37 + 5) & 8'hFF);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock: drive data, sample outputs just before the rise, rise, fall
  task automatic clk_bit(input logic [3:0] d, output logic [3:0] oe_s, output logic [3:0] out_s);
    sio_in = d;
    wait_clk(HALF);
    oe_s  = sio_oe;
    out_s = sio_out;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic begin_cmd(input logic mode3);
    sck = mode3;
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(HALF);
    if (mode3) sck = 1'b0;
  endtask

  task automatic end_cmd(input logic mode3);
    wait_clk(HALF);
    if (mode3) sck = 1'b1;
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(4);
    check(sio_oe == 4'b0000, "R4 release to hi-Z", 32'(sio_oe), 32'h0);
    wait_clk(HALF);
    sck = 1'b0;
    sio_in = 4'hF;
    wait_clk(HALF);
  endtask

  task automatic spi_byte(input logic [7:0] b, inout logic drove);
    logic [3:0] oe_s, out_s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit({3'b111, b[i]}, oe_s, out_s);
      if (oe_s != 4'b0000) drove = 1'b1;
    end
  endtask

  // read nbytes from addr; checks hi-Z in command phase and each data byte
  task automatic do_read(input logic mode3, input logic [23:0] addr, input int nbytes, input string tag);
    logic drove;
    logic bad_oe;
    logic [3:0] oe_s, out_s;
    logic [7:0] got;
    int a;
    drove = 1'b0;
    begin_cmd(mode3);
    spi_byte(8'h03, drove);
    spi_byte(addr[23:16], drove);
    spi_byte(addr[15:8], drove);
    spi_byte(addr[7:0], drove);
    check(!drove, {tag, " R5 hi-Z during opcode and address"}, 32'(drove), 32'h0);
    for (int k = 0; k < nbytes; k++) begin
      bad_oe = 1'b0;
      got = '0;
      for (int i = 0; i < 8; i++) begin
        clk_bit(4'hF, oe_s, out_s);
        got = {got[6:0], out_s[1]};
        if (oe_s != 4'b0010) bad_oe = 1'b1;
      end
      a = (int'(addr[AW-1:0]) + k) % DEPTH;
      check(got == model[a], {tag, " R1 R2 R3 R10 data byte"}, 32'(got), 32'(model[a]));
      check(!bad_oe, {tag, " R5 only lane 1 drives in data"}, 32'(bad_oe), 32'h0);
    end
    end_cmd(mode3);
  endtask

  task automatic spi_cmd(input logic [7:0] op, input int extra, input string tag);
    logic drove;
    logic [3:0] oe_s, out_s;
    drove = 1'b0;
    begin_cmd(1'b0);
    spi_byte(op, drove);
    for (int i = 0; i < extra; i++) begin
      clk_bit(4'hF, oe_s, out_s);
      if (oe_s != 4'b0000) drove = 1'b1;
    end
    check(!drove, tag, 32'(drove), 32'h0);
    end_cmd(1'b0);
  endtask

  task automatic quad_cmd(input logic [7:0] op, input int extra, input string tag);
    logic drove;
    logic [3:0] oe_s, out_s;
    drove = 1'b0;
    begin_cmd(1'b0);
    clk_bit(op[7:4], oe_s, out_s);
    if (oe_s != 4'b0000) drove = 1'b1;
    clk_bit(op[3:0], oe_s, out_s);
    if (oe_s != 4'b0000) drove = 1'b1;
    for (int i = 0; i < extra; i++) begin
      clk_bit(4'h0, oe_s, out_s);
      if (oe_s != 4'b0000) drove = 1'b1;
    end
    check(!drove, tag, 32'(drove), 32'h0);
    end_cmd(1'b0);
  endtask

  task automatic preload(input int a, input logic [7:0] v);
    @(negedge clk);
    pl_we   = 1'b1;
    pl_addr = AW'(a);
    pl_data = v;
    @(negedge clk);
    pl_we   = 1'b0;
    model[a] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check(sio_oe == 4'b0000, "reset state hi-Z", 32'(sio_oe), 32'h0);

    for (int a = 0; a < DEPTH; a++) preload(a, pattern(a)); // R12 fill

    // table walk: R1 R2 R3 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      do_read(VECS[v][28], VECS[v][27:4], int'(VECS[v][3:0]), $sformatf("vec%0d", v));
    end

    // R12: overwrite one location, read across it
    preload(7, 8'hC3);
    do_read(1'b0, 24'h000006, 3, "R12 preload");

    // R4: abort mid-stream (after 1 of many bytes), next read is fresh
    do_read(1'b1, 24'h000010, 1, "R4 abort");
    do_read(1'b0, 24'h000020, 2, "R4 fresh");

    // R11: unknown opcode, no drive; then normal read
    spi_cmd(8'h9F, 40, "R11 unknown opcode silent");
    do_read(1'b0, 24'h000040, 1, "R11 after");

    // R7: enter quad; R6: quad read ignored; R8 persistence across deselects
    spi_cmd(8'h38, 8, "R7 enter quad silent");
    quad_cmd(8'h03, 48, "R6 quad read ignored");
    quad_cmd(8'h03, 48, "R8 quad kept after deselect");
    spi_cmd(8'h03, 40, "R8 single-bit read rejected in quad");
    quad_cmd(8'hFF, 2, "R8 return opcode");
    do_read(1'b1, 24'h000055, 2, "R8 back to single-bit");

    // R8: reset clears quad mode
    spi_cmd(8'h38, 4, "R7 enter quad again");
    @(negedge clk);
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(3);
    do_read(1'b0, 24'h0000FE, 3, "R8 reset clears quad");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule